// File: doc/BRIEF.md
# SD Command Issue and Response Engine

This block is the command-path half of an SD/MMC host controller. Software loads a 32-bit argument and then writes a command word that carries a 6-bit index and four flags: response expected, long response, application command, and go. The engine builds the 48-bit command token, appends its CRC7 and shifts it out on the CMD line. If a response is expected, it then listens for a 48-bit or 136-bit reply and checks its CRC7. It loads the reply into four response words and an echo register, and reports exactly one outcome: CRC good, CRC bad or no reply.

The SD clock comes from the system clock through a fixed divider. The engine drives the CMD line just after each falling SD clock edge and samples it on each rising edge. The register port is a plain single-cycle write strobe with a combinational read. There is no back-pressure: a command write that arrives while a command is in flight is dropped. Software is expected to poll `busy` or the go bit before it issues the next command. A soft-reset bit in the command word clears the whole engine and reads back as set until that clearing has finished.

Top module: `sdcmd_engine`

## Requirements
- R1: After power-on reset, every readable register is zero. The four flags are low, `busy` is low, `cmd_oe` is low and `cmd_out` is high.
- R2: A command is sent as 48 bits, MSB first, one per SD clock period: a 0, a 1, the 6-bit index, the 32-bit argument, the CRC7 (x^7+x^3+1, zero seed) of those first 40 bits, and a final 1. `cmd_oe` is high for exactly those 48 bits, and `cmd_out` never changes at a rising SD clock edge while it is driven.
- R3: A command word whose response-expected bit is clear ends after the end bit with only `flag_sent` set.
- R4: For a short (48-bit) reply, the 32 bits that follow the index go to word 0 (offset 8), and words 1..3 (offsets 12, 16, 20) become zero. The echo register (offset 24) holds the received index in bits 5:0 and the command's application flag in bit 6.
- R5: For a long (136-bit) reply, word 0 holds reply bits 127:96, word 1 holds 95:64, word 2 holds 63:32 and word 3 holds 31:0, where bit 0 is the end bit. The echo register holds reply bits 133:128 in 5:0 and the application flag in bit 6.
- R6: The CRC7 check covers the 40 bits before the CRC for a short reply. For a long reply it covers the 120 bits after the two framing bits and the six reserved bits. A completed reply sets `flag_sent` together with exactly one of `flag_crc_ok` and `flag_crc_fail`. The response registers are loaded in either case.
- R7: If the CMD line is still high at each of the 64 rising SD edges that follow the end bit, the engine sets `flag_sent` and `flag_timeout` and leaves all response registers unchanged. A start bit seen at the 64th rising edge is still accepted.
- R8: A command-word write made while `busy` is high does not change the frame being sent, the command readback, or the outcome.
- R9: Writing bit 10 of the command word (offset 0) starts a soft reset. That bit reads 1 for SRST_CYCLES cycles and then 0. The reset aborts any command in flight, releases CMD, and returns every register and flag to its reset value.
- R10: The command register reads back the last accepted command as follows: bits 5:0 index, bit 6 response expected, bit 7 long, bit 8 application. Bit 9 reads 1 while a command is in flight, bit 10 reads 1 during soft reset, and the argument is at offset 4.
- R11: All four flags clear when a new command is accepted. They then hold until that command ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sd_clk | output | 1 | Divided SD clock |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |
| busy | output | 1 | Command in flight |
| flag_sent | output | 1 | Command finished |
| flag_crc_ok | output | 1 | Reply received with good CRC |
| flag_crc_fail | output | 1 | Reply received with bad CRC |
| flag_timeout | output | 1 | No reply start bit in the window |

## Verification
A bad bit counter shows up as a captured frame that is too long or too short, or as response words that are shifted by whole bits. Both are visible on the first command of the affected kind. A corrupted CRC register shows as the wrong CRC field on the wire, or as the wrong ok/fail flag, at the end of the same command. A wait counter that is off by one is found by the boundary pair, where a reply starts at the 64th or the 65th rising edge. The result appears within 65 SD clock periods as either a timeout flag or a loaded word. A soft reset that does not release the state leaves `busy` or `cmd_oe` high a few cycles after the reset bit clears.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SEND,
    ENG_WAIT,
    ENG_RECV
  } eng_state_t;

  // frame geometry
  localparam int TX_BITS    = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  // command word fields
  localparam int B_NEEDRSP = 6;
  localparam int B_LONG    = 7;
  localparam int B_APP     = 8;
  localparam int B_GO      = 9;
  localparam int B_SRST    = 10;

  // word indices (byte offset / 4)
  localparam int W_CMD  = 0;
  localparam int W_ARG  = 1;
  localparam int W_RSP0 = 2;
  localparam int W_RSP1 = 3;
  localparam int W_RSP2 = 4;
  localparam int W_RSP3 = 5;
  localparam int W_RCMD = 6;

  localparam logic [6:0] CRC7_POLY = 7'h09;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(logic [39:0] m);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, m[i]);
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sd_clk,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CNT_W  = $clog2(PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic at_mid, at_end;

  assign at_mid = (cnt_q == CNT_W'(HALF_DIV - 1));
  assign at_end = (cnt_q == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sd_clk  <= 1'b0;
      rise_tk <= 1'b0;
      fall_tk <= 1'b0;
    end else begin
      cnt_q   <= at_end ? '0 : cnt_q + 1'b1;
      rise_tk <= at_mid;
      fall_tk <= at_end;
      if (at_mid)      sd_clk <= 1'b1;
      else if (at_end) sd_clk <= 1'b0;
    end
  end
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  import sdcmd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdcmd_softrst.sv
module sdcmd_softrst #(
  parameter int SRST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  logic [CW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (start)  left_q <= CW'(SRST_CYCLES);
    else if (active) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int HALF_DIV    = 2,
  parameter int RSP_WAIT    = 64,
  parameter int SRST_CYCLES = 8,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sd_clk,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  output logic              busy,
  output logic              flag_sent,
  output logic              flag_crc_ok,
  output logic              flag_crc_fail,
  output logic              flag_timeout
);
  import sdcmd_pkg::*;

  localparam int WI_W = ADDR_W - 2;
  localparam int TO_W = $clog2(RSP_WAIT + 1);
  localparam int RX_W = LONG_BITS - 3;          // bits kept before the last one

  logic rise_tk, fall_tk, srst_act;
  logic [WI_W-1:0] widx;
  logic aligned, wr_cmd, wr_arg, accept, srst_go, last_bit, crc_en, crc_bit;
  logic [6:0] rx_crc;

  eng_state_t st;
  logic [5:0]  idx_q;
  logic        need_q, long_q, app_q;
  logic [31:0] arg_q;
  logic [TX_BITS-1:0] tx_sr;
  logic [7:0]  bit_q;
  logic [TO_W-1:0] wait_q;
  logic [RX_W-1:0] rx_sr;
  logic [RX_W:0]   rx_nx;
  logic [0:3][31:0] rsp_q;
  logic [6:0]  rcmd_q;
  logic [39:0] tx_head;

  sdcmd_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk), .rise_tk(rise_tk), .fall_tk(fall_tk));

  sdcmd_softrst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_n), .start(srst_go), .active(srst_act));

  sdcmd_crc7 u_rxcrc (
    .clk(clk), .rst_n(rst_n), .clr(accept | srst_act), .en(crc_en), .din(crc_bit), .crc(rx_crc));

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_cmd  = bus_wr && aligned && (widx == WI_W'(W_CMD));
  assign wr_arg  = bus_wr && aligned && (widx == WI_W'(W_ARG));
  assign srst_go = wr_cmd && bus_wdata[B_SRST] && !srst_act;
  assign accept  = wr_cmd && bus_wdata[B_GO] && !bus_wdata[B_SRST] && !srst_act
                   && (st == ENG_IDLE);
  assign busy    = (st != ENG_IDLE);
  assign tx_head = {2'b01, bus_wdata[5:0], arg_q};
  assign rx_nx   = {rx_sr, cmd_in};
  assign last_bit = (st == ENG_RECV) && rise_tk &&
                    (bit_q == (long_q ? 8'(LONG_BITS - 1) : 8'(SHORT_BITS - 1)));

  // reply bits that enter the CRC: short 0..46, long 8..134 (bit count from start)
  always_comb begin
    crc_bit = cmd_in;
    crc_en  = 1'b0;
    if (rise_tk) begin
      if (st == ENG_WAIT)
        crc_en = !cmd_in && !long_q;
      else if (st == ENG_RECV)
        crc_en = long_q ? (bit_q >= 8'd8 && bit_q <= 8'(LONG_BITS - 2))
                        : (bit_q <= 8'(SHORT_BITS - 2));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; idx_q <= '0; need_q <= 1'b0; long_q <= 1'b0; app_q <= 1'b0;
      arg_q <= '0; tx_sr <= '0; bit_q <= '0; wait_q <= '0; rx_sr <= '0;
      rsp_q <= '0; rcmd_q <= '0; cmd_out <= 1'b1; cmd_oe <= 1'b0;
      flag_sent <= 1'b0; flag_crc_ok <= 1'b0; flag_crc_fail <= 1'b0; flag_timeout <= 1'b0;
    end else if (srst_act) begin
      st <= ENG_IDLE; idx_q <= '0; need_q <= 1'b0; long_q <= 1'b0; app_q <= 1'b0;
      arg_q <= '0; tx_sr <= '0; bit_q <= '0; wait_q <= '0; rx_sr <= '0;
      rsp_q <= '0; rcmd_q <= '0; cmd_out <= 1'b1; cmd_oe <= 1'b0;
      flag_sent <= 1'b0; flag_crc_ok <= 1'b0; flag_crc_fail <= 1'b0; flag_timeout <= 1'b0;
    end else begin
      if (wr_arg) arg_q <= bus_wdata;
      case (st)
        ENG_IDLE: if (accept) begin
          idx_q  <= bus_wdata[5:0];
          need_q <= bus_wdata[B_NEEDRSP];
          long_q <= bus_wdata[B_LONG];
          app_q  <= bus_wdata[B_APP];
          tx_sr  <= {tx_head, crc7_of40(tx_head), 1'b1};
          bit_q  <= '0;
          flag_sent <= 1'b0; flag_crc_ok <= 1'b0; flag_crc_fail <= 1'b0; flag_timeout <= 1'b0;
          st <= ENG_SEND;
        end
        ENG_SEND: if (fall_tk) begin
          if (bit_q == 8'(TX_BITS)) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            bit_q   <= '0;
            wait_q  <= '0;
            if (need_q) st <= ENG_WAIT;
            else begin
              flag_sent <= 1'b1;
              st <= ENG_IDLE;
            end
          end else begin
            cmd_oe  <= 1'b1;
            cmd_out <= tx_sr[TX_BITS-1];
            tx_sr   <= {tx_sr[TX_BITS-2:0], 1'b0};
            bit_q   <= bit_q + 1'b1;
          end
        end
        ENG_WAIT: if (rise_tk) begin
          if (!cmd_in) begin
            st    <= ENG_RECV;
            bit_q <= 8'd1;
            rx_sr <= '0;
          end else if (wait_q == TO_W'(RSP_WAIT - 1)) begin
            flag_sent    <= 1'b1;
            flag_timeout <= 1'b1;
            st <= ENG_IDLE;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ENG_RECV: if (rise_tk) begin
          rx_sr <= rx_nx[RX_W-1:0];
          bit_q <= bit_q + 1'b1;
          if (last_bit) begin
            st            <= ENG_IDLE;
            flag_sent     <= 1'b1;
            flag_crc_ok   <= (rx_crc == 7'd0);
            flag_crc_fail <= (rx_crc != 7'd0);
            if (long_q) begin
              rsp_q  <= rx_nx[127:0];
              rcmd_q <= {app_q, rx_nx[133:128]};
            end else begin
              rsp_q  <= {rx_nx[39:8], 96'd0};
              rcmd_q <= {app_q, rx_nx[45:40]};
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (int'(widx))
        W_CMD:  bus_rdata = {21'd0, srst_act, busy, app_q, long_q, need_q, idx_q};
        W_ARG:  bus_rdata = arg_q;
        W_RSP0: bus_rdata = rsp_q[0];
        W_RSP1: bus_rdata = rsp_q[1];
        W_RSP2: bus_rdata = rsp_q[2];
        W_RSP3: bus_rdata = rsp_q[3];
        W_RCMD: bus_rdata = {25'd0, rcmd_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic sd_clk,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic flag_sent,
  input logic flag_crc_ok,
  input logic flag_crc_fail,
  input logic flag_timeout
);
  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_crc_ok, flag_crc_fail, flag_timeout}) <= 1);

  // R6
  outcome_with_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_crc_ok || flag_crc_fail || flag_timeout) |-> flag_sent);

  // R2
  drive_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  // R2
  stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sd_clk) && cmd_oe && $past(cmd_oe)) |-> $stable(cmd_out));

  // R11
  flags_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !flag_sent && !flag_timeout);

  // R3
  sent_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_sent) |-> $fell(busy));
endmodule

bind sdcmd_engine sdcmd_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
  .busy(busy), .flag_sent(flag_sent), .flag_crc_ok(flag_crc_ok),
  .flag_crc_fail(flag_crc_fail), .flag_timeout(flag_timeout));

// File: tb/test_sdcmd_engine.sv
module test_sdcmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int RSP_WAIT   = 64;
  localparam int SRST       = 8;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, cmd_in = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sd_clk, cmd_out, cmd_oe, busy, flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout;

  int n_tests = 0, n_fail = 0;
  int cap_n = 0;
  logic [47:0] cap_sr = '0;
  logic [0:3][31:0] m_w = '0;
  logic [6:0] m_rc = '0;

  sdcmd_engine #(.HALF_DIV(2), .RSP_WAIT(RSP_WAIT), .SRST_CYCLES(SRST), .ADDR_W(5)) i_sdcmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
    .busy(busy), .flag_sent(flag_sent), .flag_crc_ok(flag_crc_ok),
    .flag_crc_fail(flag_crc_fail), .flag_timeout(flag_timeout));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge sd_clk) if (cmd_oe) begin
    cap_sr = {cap_sr[46:0], cmd_out};
    cap_n  = cap_n + 1;
  end

  function automatic logic [6:0] ref_crc(input logic [119:0] m, input int n);
    logic [126:0] w;
    w = {m, 7'd0};
    for (int i = n + 6; i >= 7; i--)
      if (w[i]) w[i -: 8] = w[i -: 8] ^ 8'h89;
    return w[6:0];
  endfunction

  task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(5'(8 + 4*k), d); chk(tag, d, m_w[k]);
    end
    rd(5'd24, d); chk(tag, d, {25'd0, m_rc});
  endtask

  // mode 0: good reply, 1: bad CRC, 2: no reply; dly = falling edge of first reply bit
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic need,
                         input logic lng, input logic app, input int mode, input int dly,
                         input logic [31:0] seed);
    logic [135:0] rf;
    logic [39:0] hd;
    logic [119:0] pay;
    logic [5:0] ridx;
    logic [31:0] d;
    int nb;
    logic tmo;
    cap_n = 0;
    wr(5'd4, arg);
    wr(5'd0, {21'd0, 1'b0, 1'b1, app, lng, need, idx});
    chk("R11 flags cleared on accept", {busy, flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout}, 5'b10000);
    rd(5'd0, d);
    chk("R10 readback while busy", d, {21'd0, 1'b0, 1'b1, app, lng, need, idx});
    wait (cap_n == 48);
    hd = {2'b01, idx, arg};
    chk("R2 command frame", cap_sr, {hd, ref_crc(120'(hd), 40), 1'b1});
    if (idx == 6'd0 && arg == 32'd0) chk("R2 known CRC of idle command", cap_sr, 48'h400000000095);
    ridx = idx ^ 6'h2A;
    pay  = {arg, ~arg, seed, seed[23:0]};
    if (lng) begin
      rf = {2'b00, 6'h3F, pay, ref_crc(pay, 120), 1'b1};
      nb = 136;
    end else begin
      rf = 136'({2'b00, ridx, seed, ref_crc(120'({2'b00, ridx, seed}), 40), 1'b1});
      nb = 48;
    end
    if (mode == 1) rf[1] = ~rf[1];
    if (need && mode != 2) begin
      repeat (dly - 1) @(negedge sd_clk);
      for (int i = nb - 1; i >= 0; i--) begin
        @(negedge sd_clk); cmd_in = rf[i];
      end
      @(negedge sd_clk); cmd_in = 1'b1;
    end
    do @(negedge clk); while (busy);
    chk("R2 frame length", cap_n, 48);
    tmo = need && (mode == 2 || dly > RSP_WAIT);
    if (!need)
      chk("R3 no-reply outcome", {flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout}, 4'b1000);
    else if (tmo)
      chk("R7 timeout outcome", {flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout}, 4'b1001);
    else
      chk("R6 CRC outcome", {flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout},
          {1'b1, mode == 0, mode == 1, 1'b0});
    if (need && !tmo) begin
      if (lng) begin m_w = rf[127:0]; m_rc = {app, 6'h3F}; end
      else     begin m_w = {seed, 96'd0}; m_rc = {app, ridx}; end
    end
    if (!need)      check_regs("R3 registers kept");
    else if (tmo)   check_regs("R7 registers kept");
    else if (lng)   check_regs("R5 long reply words");
    else            check_regs("R4 short reply words");
    rd(5'd0, d);
    chk("R10 readback when idle", d, {21'd0, 1'b0, 1'b0, app, lng, need, idx});
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {busy, cmd_oe, cmd_out, flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout}, 7'b0010000);
    for (int k = 0; k < 7; k++) begin
      rd(5'(4*k), d); chk("R1 reset register", d, 32'd0);
    end

    run_cmd(6'd0, 32'd0, 1'b0, 1'b0, 1'b0, 0, 1, 32'd0);

    for (int n = 0; n < 16; n++)
      run_cmd(6'(n * 5 + 3), 32'h1234_5678 ^ (n * 32'h0101_1011), n[0], n[1], n[2],
              n[3] ? 1 : 0, 1 + (n % 4) * 3, 32'hC0DE_0000 + n);

    // R7 boundaries
    run_cmd(6'd17, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 0, 64, 32'h0BAD_F00D);
    run_cmd(6'd18, 32'hFEED_0001, 1'b1, 1'b0, 1'b0, 0, 65, 32'h7777_1111);
    run_cmd(6'd2,  32'h0000_00FF, 1'b1, 1'b1, 1'b0, 2, 1, 32'h0);
    run_cmd(6'd9,  32'hA5A5_5A5A, 1'b1, 1'b1, 1'b1, 0, 64, 32'h1357_9BDF);

    // R8: second command write while the first is in flight
    cap_n = 0;
    wr(5'd4, 32'h0F0F_F0F0);
    wr(5'd0, {21'd0, 1'b0, 1'b1, 3'b000, 6'd12});
    wr(5'd0, {21'd0, 1'b0, 1'b1, 3'b111, 6'd33});
    wait (cap_n == 48);
    chk("R8 frame unchanged", cap_sr,
        {2'b01, 6'd12, 32'h0F0F_F0F0, ref_crc(120'({2'b01, 6'd12, 32'h0F0F_F0F0}), 40), 1'b1});
    do @(negedge clk); while (busy);
    chk("R8 outcome unchanged", {flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout}, 4'b1000);
    rd(5'd0, d);
    chk("R8 readback unchanged", d, {21'd0, 1'b0, 1'b0, 3'b000, 6'd12});

    // R9: soft reset in the middle of a frame
    cap_n = 0;
    wr(5'd4, 32'h2468_ACE0);
    wr(5'd0, {21'd0, 1'b0, 1'b1, 3'b011, 6'd41});
    wait (cap_n == 10);
    wr(5'd0, 32'h0000_0400);
    rd(5'd0, d);
    chk("R9 reset bit set", d[10], 1'b1);
    repeat (SRST + 2) @(negedge clk);
    rd(5'd0, d);
    chk("R9 reset bit self-clears", d, 32'd0);
    chk("R9 engine released", {busy, cmd_oe, cmd_out, flag_sent, flag_crc_ok, flag_crc_fail, flag_timeout}, 7'b0010000);
    chk("R9 no further bits", cap_n, 10);
    m_w = '0; m_rc = '0;
    check_regs("R9 registers cleared");
    rd(5'd4, d);
    chk("R9 argument cleared", d, 32'd0);

    run_cmd(6'd55, 32'h8000_0001, 1'b1, 1'b0, 1'b1, 0, 2, 32'hFACE_CAFE);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule